// File: doc/BRIEF.md
# Linked-Table Address Translator

This block sits on the address path between a trace DMA writer and memory. It turns the writer's linear input addresses into addresses inside scattered 4 KB physical pages. The page mapping lives in memory as a chain of 4 KB table pages. Each table page maps one megabyte of input space through 256 data-page entries. Two slots near the end of each table page point to the neighbouring tables in the chain. To reach the table that covers a request, the walker follows these links forward or backward from the table it used last.

Each entry is 64 bits wide. The page address sits in the bits from 12 upward, and bit 0 is the valid flag. Software sets up the first table's page number and the megabyte-aligned input base while the unit is disabled, then raises the enable. In pass-through mode each address comes back unchanged and no memory is read. Requests are handled one at a time. Each one ends in a single response cycle that carries either a translated address or an error flag.

Top module: `chain_xlat`

## Requirements
- R1: After reset, stat_ready is 1 and req_ready, mem_req and rsp_valid are 0, and the remembered table position is invalid.
- R2: cfg_translate (1 = translate, 0 = pass-through), cfg_table_page and cfg_in_base_mb are taken in only on cycles when the unit is disabled and idle; changing them while enabled has no effect until the next enable.
- R3: In pass-through mode the response comes exactly one cycle after acceptance, with rsp_addr equal to req_addr, rsp_err 0 and no memory read.
- R4: In translate mode, d = req_addr[ADDR_W-1:20] - cfg_in_base_mb selects table d of the chain (table 0 is at page cfg_table_page). req_addr[19:12] selects the entry, which is read at the table's byte address plus 8 × index. The response is rsp_addr = {entry[ADDR_W-1:12], req_addr[11:0]}.
- R5: The forward link is the entry at byte offset 0xFF8 of a table page (entry 511) and the backward link is at 0xFF0 (entry 510). The walker reads one link per step towards the target table, so a request costs |d - current table| + 1 memory reads.
- R6: The table reached by a walk stays current for the next request. The first translated request after enable starts from table 0, and disabling the unit forgets the position.
- R7: An input address below the base gives rsp_valid with rsp_err one cycle after acceptance, with no memory read.
- R8: A data or link entry whose bit 0 is clear ends the request with rsp_err set and rsp_addr 0. The current position stays at the last table reached, so a missing forward link leaves the walker on the last table of the chain.
- R9: req_ready is 0 while the unit is disabled, and from acceptance until the cycle in which the response is presented.
- R10: stat_ready is 0 while a request is in flight and 1 otherwise. Clearing cfg_enable during a walk lets the walk finish with its normal response. After that, stat_ready is 1 and req_ready is 0.
- R11: mem_req stays high with mem_addr unchanged until the cycle in which mem_rvalid is 1. mem_rdata is taken in that cycle, and mem_req is 0 in the following cycle.
- R12: With STRICT_ENTRY = 1 (the default), an entry is also invalid if any of its bits [11:1] is set or any bit above ADDR_W-1 is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_enable | input | 1 | Unit enable |
| cfg_translate | input | 1 | 1 = walk tables, 0 = pass-through |
| cfg_table_page | input | ADDR_W-12 | Physical page number of table 0 |
| cfg_in_base_mb | input | ADDR_W-20 | Input base address in megabyte units |
| stat_ready | output | 1 | No request in flight |
| req_valid | input | 1 | Request offered |
| req_addr | input | ADDR_W | Linear input address |
| req_ready | output | 1 | Request accepted when high with req_valid |
| mem_req | output | 1 | Table entry read pending |
| mem_addr | output | ADDR_W | Byte address of the 64-bit entry |
| mem_rvalid | input | 1 | Read data returned this cycle |
| mem_rdata | input | 64 | Entry read from memory |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_addr | output | ADDR_W | Translated address, 0 on error |
| rsp_err | output | 1 | Lookup failed |

## Verification
A pass-through result and an out-of-range error are due exactly one cycle after the edge that accepts the request. The bench counts falling edges from that acceptance and requires the strobe on the first of them. A table walk takes a number of cycles that depends on memory latency, which the bench's memory model varies at random from zero to three cycles. For those requests the bench does not fix a cycle. Instead it samples every falling edge until the strobe, requires req_ready to stay low on each of those edges, and checks the number of entry reads against the count predicted by its own model of the walker's table position. All outputs are sampled on falling edges, half a period after the registers that drive them have settled.

// File: rtl/chain_xlat_pkg.sv
package chain_xlat_pkg;

   // 4 KB pages, 8-byte entries
   localparam int unsigned PG_SH  = 12;
   localparam int unsigned ENT_SH = 3;
   localparam int unsigned ENT_W  = 64;
   // slots per table page and data entries per table
   localparam int unsigned SLOT_W = PG_SH - ENT_SH;
   localparam int unsigned IDX_W  = 8;
   // one table spans 2^TBL_SH bytes of input space
   localparam int unsigned TBL_SH = PG_SH + IDX_W;

   // link slots at the top of each table page
   localparam logic [SLOT_W-1:0] SLOT_NEXT = {SLOT_W{1'b1}};
   localparam logic [SLOT_W-1:0] SLOT_PREV = {{(SLOT_W-1){1'b1}}, 1'b0};

   typedef enum logic [1:0] {
      WK_IDLE,
      WK_SEEK,
      WK_LINK,
      WK_DATA
   } wk_state_e;

endpackage

// File: rtl/chain_xlat_cfg.sv
module chain_xlat_cfg
   import chain_xlat_pkg::*;
#(
   parameter int unsigned ADDR_W = 40
)(
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       cfg_enable,
   input  logic                       cfg_translate,
   input  logic [ADDR_W-PG_SH-1:0]    cfg_table_page,
   input  logic [ADDR_W-TBL_SH-1:0]   cfg_in_base_mb,
   input  logic                       walk_idle,
   output logic                       en_q,
   output logic                       xlate_q,
   output logic [ADDR_W-PG_SH-1:0]    tpage_q,
   output logic [ADDR_W-TBL_SH-1:0]   inmb_q
);

   logic load;
   assign load = !en_q && walk_idle;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en_q    <= 1'b0;
         xlate_q <= 1'b0;
         tpage_q <= '0;
         inmb_q  <= '0;
      end else begin
         en_q <= cfg_enable;
         if (load) begin
            xlate_q <= cfg_translate;
            tpage_q <= cfg_table_page;
            inmb_q  <= cfg_in_base_mb;
         end
      end
   end

   AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      (en_q && $past(en_q)) |-> $stable({xlate_q, tpage_q, inmb_q})); // R2

endmodule

// File: rtl/chain_xlat_locate.sv
module chain_xlat_locate
   import chain_xlat_pkg::*;
#(
   parameter int unsigned ADDR_W = 40
)(
   input  logic [ADDR_W-1:0]          addr,
   input  logic [ADDR_W-TBL_SH-1:0]   inmb,
   output logic                       below,
   output logic [ADDR_W-TBL_SH-1:0]   tnum,
   output logic [IDX_W-1:0]           idx,
   output logic [PG_SH-1:0]           pgoff
);

   logic [ADDR_W-TBL_SH-1:0] mb;

   assign mb    = addr[ADDR_W-1:TBL_SH];
   assign below = mb < inmb;
   assign tnum  = mb - inmb;
   assign idx   = addr[TBL_SH-1:PG_SH];
   assign pgoff = addr[PG_SH-1:0];

endmodule

// File: rtl/chain_xlat_entry.sv
module chain_xlat_entry
   import chain_xlat_pkg::*;
#(
   parameter int unsigned ADDR_W = 40,
   parameter bit          STRICT = 1'b1
)(
   input  logic [ENT_W-1:0]          ent,
   output logic                      ok,
   output logic [ADDR_W-PG_SH-1:0]   page
);

   logic hi_clear;

   assign hi_clear = (ent[ENT_W-1:ADDR_W] == '0);
   assign page     = ent[ADDR_W-1:PG_SH];

   generate
      if (STRICT) begin : g_strict
         assign ok = ent[0] && hi_clear && (ent[PG_SH-1:1] == '0);
      end else begin : g_loose
         logic sbz_unused;
         assign sbz_unused = ^ent[PG_SH-1:1];
         assign ok = ent[0] && hi_clear;
      end
   endgenerate

endmodule

// File: rtl/chain_xlat_walker.sv
module chain_xlat_walker
   import chain_xlat_pkg::*;
#(
   parameter int unsigned ADDR_W = 40,
   parameter bit          STRICT = 1'b1
)(
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       en,
   input  logic                       xlate,
   input  logic [ADDR_W-PG_SH-1:0]    tpage,
   input  logic [ADDR_W-TBL_SH-1:0]   inmb,
   input  logic                       req_valid,
   input  logic [ADDR_W-1:0]          req_addr,
   output logic                       req_ready,
   output logic                       mem_req,
   output logic [ADDR_W-1:0]          mem_addr,
   input  logic                       mem_rvalid,
   input  logic [ENT_W-1:0]           mem_rdata,
   output logic                       rsp_valid,
   output logic [ADDR_W-1:0]          rsp_addr,
   output logic                       rsp_err,
   output logic                       idle
);

   localparam int unsigned PG_W = ADDR_W - PG_SH;
   localparam int unsigned TN_W = ADDR_W - TBL_SH;
   localparam logic [TN_W-1:0] T_ONE = TN_W'(1);

   wk_state_e          state_q;
   logic               cvld_q;
   logic [TN_W-1:0]    cur_tnum_q;
   logic [PG_W-1:0]    cur_page_q;
   logic [TN_W-1:0]    tgt_tnum_q;
   logic [IDX_W-1:0]   tgt_idx_q;
   logic [PG_SH-1:0]   pgoff_q;
   logic               fwd_q;

   logic               loc_below;
   logic [TN_W-1:0]    loc_tnum;
   logic [IDX_W-1:0]   loc_idx;
   logic [PG_SH-1:0]   loc_pgoff;
   logic               ent_ok;
   logic [PG_W-1:0]    ent_page;
   logic               accept;

   chain_xlat_locate #(.ADDR_W(ADDR_W)) u_loc (
      .addr  (req_addr),
      .inmb  (inmb),
      .below (loc_below),
      .tnum  (loc_tnum),
      .idx   (loc_idx),
      .pgoff (loc_pgoff)
   );

   chain_xlat_entry #(.ADDR_W(ADDR_W), .STRICT(STRICT)) u_ent (
      .ent  (mem_rdata),
      .ok   (ent_ok),
      .page (ent_page)
   );

   assign idle      = (state_q == WK_IDLE);
   assign req_ready = en && idle;
   assign accept    = req_valid && req_ready;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q    <= WK_IDLE;
         cvld_q     <= 1'b0;
         cur_tnum_q <= '0;
         cur_page_q <= '0;
         tgt_tnum_q <= '0;
         tgt_idx_q  <= '0;
         pgoff_q    <= '0;
         fwd_q      <= 1'b0;
         mem_req    <= 1'b0;
         mem_addr   <= '0;
         rsp_valid  <= 1'b0;
         rsp_addr   <= '0;
         rsp_err    <= 1'b0;
      end else begin
         rsp_valid <= 1'b0;
         rsp_err   <= 1'b0;
         if (!en && idle) begin
            cvld_q <= 1'b0;
         end
         unique case (state_q)
            WK_IDLE: begin
               if (accept) begin
                  if (!xlate) begin
                     rsp_valid <= 1'b1;
                     rsp_addr  <= req_addr;
                  end else if (loc_below) begin
                     rsp_valid <= 1'b1;
                     rsp_err   <= 1'b1;
                     rsp_addr  <= '0;
                  end else begin
                     tgt_tnum_q <= loc_tnum;
                     tgt_idx_q  <= loc_idx;
                     pgoff_q    <= loc_pgoff;
                     if (!cvld_q) begin
                        cvld_q     <= 1'b1;
                        cur_tnum_q <= '0;
                        cur_page_q <= tpage;
                     end
                     state_q <= WK_SEEK;
                  end
               end
            end
            WK_SEEK: begin
               mem_req <= 1'b1;
               if (tgt_tnum_q == cur_tnum_q) begin
                  mem_addr <= {cur_page_q, {(SLOT_W-IDX_W){1'b0}}, tgt_idx_q,
                               {ENT_SH{1'b0}}};
                  state_q  <= WK_DATA;
               end else if (tgt_tnum_q > cur_tnum_q) begin
                  mem_addr <= {cur_page_q, SLOT_NEXT, {ENT_SH{1'b0}}};
                  fwd_q    <= 1'b1;
                  state_q  <= WK_LINK;
               end else begin
                  mem_addr <= {cur_page_q, SLOT_PREV, {ENT_SH{1'b0}}};
                  fwd_q    <= 1'b0;
                  state_q  <= WK_LINK;
               end
            end
            WK_LINK: begin
               if (mem_rvalid) begin
                  mem_req <= 1'b0;
                  if (ent_ok) begin
                     cur_page_q <= ent_page;
                     cur_tnum_q <= fwd_q ? (cur_tnum_q + T_ONE) : (cur_tnum_q - T_ONE);
                     state_q    <= WK_SEEK;
                  end else begin
                     rsp_valid <= 1'b1;
                     rsp_err   <= 1'b1;
                     rsp_addr  <= '0;
                     state_q   <= WK_IDLE;
                  end
               end
            end
            WK_DATA: begin
               if (mem_rvalid) begin
                  mem_req   <= 1'b0;
                  rsp_valid <= 1'b1;
                  state_q   <= WK_IDLE;
                  if (ent_ok) begin
                     rsp_addr <= {ent_page, pgoff_q};
                  end else begin
                     rsp_err  <= 1'b1;
                     rsp_addr <= '0;
                  end
               end
            end
            default: state_q <= WK_IDLE;
         endcase
      end
   end

   AST_PASS_NO_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
      !xlate |-> !mem_req); // R3

   AST_FETCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_rvalid) |=> (mem_req && $stable(mem_addr))); // R11

   AST_ERR_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_err |-> (rsp_valid && (rsp_addr == '0))); // R8

   AST_NO_ACCEPT_IN_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> !req_ready); // R9

endmodule

// File: rtl/chain_xlat.sv
module chain_xlat
   import chain_xlat_pkg::*;
#(
   parameter int unsigned ADDR_W       = 40,
   parameter bit          STRICT_ENTRY = 1'b1
)(
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       cfg_enable,
   input  logic                       cfg_translate,
   input  logic [ADDR_W-PG_SH-1:0]    cfg_table_page,
   input  logic [ADDR_W-TBL_SH-1:0]   cfg_in_base_mb,
   output logic                       stat_ready,
   input  logic                       req_valid,
   input  logic [ADDR_W-1:0]          req_addr,
   output logic                       req_ready,
   output logic                       mem_req,
   output logic [ADDR_W-1:0]          mem_addr,
   input  logic                       mem_rvalid,
   input  logic [ENT_W-1:0]           mem_rdata,
   output logic                       rsp_valid,
   output logic [ADDR_W-1:0]          rsp_addr,
   output logic                       rsp_err
);

   generate
      if (ADDR_W < 32 || ADDR_W > 56) begin : g_bad_width
         $error("chain_xlat: ADDR_W must lie in 32..56");
      end
   endgenerate

   logic                      en_q;
   logic                      xlate_q;
   logic [ADDR_W-PG_SH-1:0]   tpage_q;
   logic [ADDR_W-TBL_SH-1:0]  inmb_q;
   logic                      walk_idle;

   chain_xlat_cfg #(.ADDR_W(ADDR_W)) u_cfg (
      .clk            (clk),
      .rst_n          (rst_n),
      .cfg_enable     (cfg_enable),
      .cfg_translate  (cfg_translate),
      .cfg_table_page (cfg_table_page),
      .cfg_in_base_mb (cfg_in_base_mb),
      .walk_idle      (walk_idle),
      .en_q           (en_q),
      .xlate_q        (xlate_q),
      .tpage_q        (tpage_q),
      .inmb_q         (inmb_q)
   );

   chain_xlat_walker #(.ADDR_W(ADDR_W), .STRICT(STRICT_ENTRY)) u_walk (
      .clk        (clk),
      .rst_n      (rst_n),
      .en         (en_q),
      .xlate      (xlate_q),
      .tpage      (tpage_q),
      .inmb       (inmb_q),
      .req_valid  (req_valid),
      .req_addr   (req_addr),
      .req_ready  (req_ready),
      .mem_req    (mem_req),
      .mem_addr   (mem_addr),
      .mem_rvalid (mem_rvalid),
      .mem_rdata  (mem_rdata),
      .rsp_valid  (rsp_valid),
      .rsp_addr   (rsp_addr),
      .rsp_err    (rsp_err),
      .idle       (walk_idle)
   );

   assign stat_ready = walk_idle;

   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      stat_ready |-> !mem_req); // R10

endmodule

// File: tb/tb_chain_xlat.sv
module tb_chain_xlat;

   localparam int CLK_PERIOD = 10;
   localparam int AW = 40;
   localparam int NT = 4;
   localparam logic [19:0] BASE_MB = 20'h00400;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           cfg_enable = 1'b0;
   logic           cfg_translate = 1'b0;
   logic [27:0]    cfg_table_page = '0;
   logic [19:0]    cfg_in_base_mb = '0;
   logic           stat_ready;
   logic           req_valid = 1'b0;
   logic [AW-1:0]  req_addr = '0;
   logic           req_ready;
   logic           mem_req;
   logic [AW-1:0]  mem_addr;
   logic           mem_rvalid = 1'b0;
   logic [63:0]    mem_rdata = '0;
   logic           rsp_valid;
   logic [AW-1:0]  rsp_addr;
   logic           rsp_err;

   int n_chk = 0;
   int n_err = 0;
   int rd_count = 0;
   int wait_cnt = 0;
   int lat = 0;
   int wd = 0;
   int cur_m = 0;
   bit cv_m = 1'b0;

   logic [63:0] mem_img [logic [AW-1:0]];

   always #(CLK_PERIOD/2) clk = ~clk;

   chain_xlat #(.ADDR_W(AW), .STRICT_ENTRY(1'b1)) dut (
      .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .cfg_translate(cfg_translate),
      .cfg_table_page(cfg_table_page), .cfg_in_base_mb(cfg_in_base_mb),
      .stat_ready(stat_ready), .req_valid(req_valid), .req_addr(req_addr),
      .req_ready(req_ready), .mem_req(mem_req), .mem_addr(mem_addr),
      .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .rsp_valid(rsp_valid),
      .rsp_addr(rsp_addr), .rsp_err(rsp_err)
   );

   function automatic logic [27:0] tpg(int t);
      return 28'h00A0000 + 28'(t * 311);
   endfunction

   function automatic logic [27:0] dpg(int t, int k);
      return 28'h3000000 + 28'((t * 256 + k) * 5);
   endfunction

   function automatic logic [63:0] data_entry(int t, int k);
      logic [63:0] e;
      e = {24'h0, dpg(t, k), 12'h001};
      if (t == 2 && k == 7) e = '0;
      if (t == 1 && k == 9) e = e | 64'h20;
      if (t == 3 && k == 200) e = e | (64'h1 << 50);
      return e;
   endfunction

   function automatic logic [AW-1:0] mk(int t, int k, int o);
      return {BASE_MB + 20'(t), 8'(k), 12'(o)};
   endfunction

   // memory model: random latency 0..3, one-cycle data strobe
   always @(negedge clk) begin
      if (mem_rvalid) begin
         mem_rvalid = 1'b0;
      end else if (mem_req) begin
         if (wait_cnt >= lat) begin
            mem_rvalid = 1'b1;
            mem_rdata  = mem_img.exists(mem_addr) ? mem_img[mem_addr] : 64'h0;
            rd_count++;
            wait_cnt = 0;
            lat = int'($urandom % 4);
         end else begin
            wait_cnt++;
         end
      end
   end

   task automatic chk(input string tag, input string what, input logic [63:0] act,
                      input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
      end
   endtask

   task automatic send(input logic [AW-1:0] a, input bit drop_en, output bit e,
                       output logic [AW-1:0] pa, output int cyc, output int nrd,
                       output bit busy_ok, output bit sr_mid);
      @(negedge clk);
      rd_count = 0;
      req_valid = 1'b1;
      req_addr = a;
      while (!req_ready) @(negedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      cyc = 1;
      busy_ok = 1'b1;
      sr_mid = stat_ready;
      if (drop_en) cfg_enable = 1'b0;
      while (!rsp_valid) begin
         if (req_ready) busy_ok = 1'b0;
         @(negedge clk);
         cyc++;
      end
      e = rsp_err;
      pa = rsp_addr;
      nrd = rd_count;
   endtask

   // reference model of the walker position and result
   task automatic model(input logic [AW-1:0] a, output bit e, output logic [AW-1:0] pa,
                        output int n);
      logic [19:0] mb;
      logic [63:0] ent;
      int t, k;
      mb = a[AW-1:20];
      pa = '0;
      if (mb < BASE_MB) begin
         e = 1'b1; n = 0; return;
      end
      t = int'(mb - BASE_MB);
      k = int'(a[19:12]);
      if (!cv_m) begin
         cv_m = 1'b1; cur_m = 0;
      end
      if (t >= NT) begin
         n = NT - cur_m; cur_m = NT - 1; e = 1'b1; return;
      end
      n = ((t > cur_m) ? (t - cur_m) : (cur_m - t)) + 1;
      cur_m = t;
      ent = data_entry(t, k);
      if (ent[0] && ent[11:1] == 0 && ent[63:AW] == 0) begin
         e = 1'b0; pa = {ent[AW-1:12], a[11:0]};
      end else begin
         e = 1'b1;
      end
   endtask

   task automatic xreq(input logic [AW-1:0] a, input string tag);
      bit e, xe, bok, srm;
      logic [AW-1:0] pa, xpa;
      int cyc, nrd, xn;
      model(a, xe, xpa, xn);
      send(a, 1'b0, e, pa, cyc, nrd, bok, srm);
      chk(tag, "rsp_err", 64'(e), 64'(xe));
      chk(tag, "rsp_addr", 64'(pa), 64'(xpa));
      chk("R5", "entry reads", 64'(nrd), 64'(xn));
      if (xn == 0) chk("R7", "latency", 64'(cyc), 64'd1);
      else begin
         chk("R9", "req_ready low in walk", 64'(bok), 64'd1);
         chk("R11", "mem_req low at response", 64'(mem_req), 64'd0);
      end
   endtask

   task automatic preq(input logic [AW-1:0] a, input string tag);
      bit e, bok, srm;
      logic [AW-1:0] pa;
      int cyc, nrd;
      send(a, 1'b0, e, pa, cyc, nrd, bok, srm);
      chk(tag, "pass addr", 64'(pa), 64'(a));
      chk(tag, "pass err", 64'(e), 64'd0);
      chk(tag, "pass latency", 64'(cyc), 64'd1);
      chk(tag, "pass reads", 64'(nrd), 64'd0);
   endtask

   always @(posedge clk) begin
      wd++;
      if (wd > 150000) begin
         n_chk++;
         n_err++;
         $display("FAIL watchdog (R9): cycles %0d expected below %0d", wd, 150000);
         $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
         $finish;
      end
   end

   initial begin
      bit e, bok, srm, xe;
      logic [AW-1:0] pa, xpa;
      int cyc, nrd, xn;
      void'($urandom(32'h5EED_1234));
      for (int t = 0; t < NT; t++) begin
         for (int k = 0; k < 256; k++) mem_img[{tpg(t), 1'b0, 8'(k), 3'b000}] = data_entry(t, k);
         mem_img[{tpg(t), 9'h1FF, 3'b000}] = (t < NT - 1) ? {24'h0, tpg(t + 1), 12'h001} : 64'h0;
         mem_img[{tpg(t), 9'h1FE, 3'b000}] = (t > 0) ? {24'h0, tpg(t - 1), 12'h001} : 64'h0;
      end

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1", "stat_ready", 64'(stat_ready), 64'd1);
      chk("R1", "req_ready", 64'(req_ready), 64'd0);
      chk("R1", "mem_req", 64'(mem_req), 64'd0);
      chk("R1", "rsp_valid", 64'(rsp_valid), 64'd0);

      // pass-through
      cfg_translate = 1'b0;
      cfg_table_page = tpg(0);
      cfg_in_base_mb = BASE_MB;
      cfg_enable = 1'b1;
      for (int i = 0; i < 6; i++) preq({8'($urandom), 32'($urandom)}, "R3");

      // configuration changes while enabled are ignored
      @(negedge clk);
      cfg_translate = 1'b1;
      preq(mk(1, 3, 5), "R2");

      // re-enable in translate mode
      @(negedge clk);
      cfg_enable = 1'b0;
      repeat (3) @(negedge clk);
      chk("R9", "req_ready while disabled", 64'(req_ready), 64'd0);
      cfg_enable = 1'b1;
      cv_m = 1'b0;

      xreq(mk(2, 5, 12'h123), "R6");
      xreq(mk(0, 0, 0), "R5");
      xreq(mk(0, 255, 12'hFFF), "R6");
      xreq(mk(3, 17, 12'h0A4), "R5");
      xreq(mk(1, 1, 12'h777), "R4");
      xreq({BASE_MB - 20'd1, 20'hFFFFF}, "R7");
      xreq(mk(2, 7, 12'h010), "R8");
      xreq(mk(2, 8, 12'h020), "R6");
      xreq(mk(1, 9, 12'h030), "R12");
      xreq(mk(3, 200, 12'h040), "R12");
      xreq(mk(NT, 3, 12'h050), "R8");
      xreq(mk(3, 4, 12'h060), "R6");

      for (int i = 0; i < 200; i++) begin
         int r, t;
         logic [AW-1:0] a;
         r = int'($urandom % 16);
         t = int'($urandom % NT);
         if (r == 0) a = {BASE_MB - 20'(1 + $urandom % 4), 20'($urandom)};
         else if (r == 1) a = mk(NT, int'($urandom % 256), int'($urandom % 4096));
         else a = mk(t, int'($urandom % 256), int'($urandom % 4096));
         xreq(a, "R4");
      end

      // clearing enable in the middle of a walk
      xreq(mk(0, 2, 12'h002), "R6");
      model(mk(3, 9, 12'h345), xe, xpa, xn);
      send(mk(3, 9, 12'h345), 1'b1, e, pa, cyc, nrd, bok, srm);
      chk("R10", "stat_ready mid walk", 64'(srm), 64'd0);
      chk("R10", "walk result after disable", 64'(pa), 64'(xpa));
      chk("R10", "walk err after disable", 64'(e), 64'(xe));
      chk("R10", "stat_ready after drain", 64'(stat_ready), 64'd1);
      chk("R9", "req_ready after drain", 64'(req_ready), 64'd0);
      cv_m = 1'b0;
      repeat (3) @(negedge clk);
      cfg_enable = 1'b1;
      xreq(mk(1, 40, 12'h99), "R6");

      repeat (3) @(negedge clk);
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

endmodule